// File: doc/BRIEF.md
# Reference Clock Period Supervisor

This block supervises two reference clocks that arrive from the backplane with no known phase relation to the local bus clock. Each input is brought into the bus clock domain through a synchronizer. The block counts how many bus clock cycles pass between consecutive rising edges and keeps the latest result as a live 16-bit period. It also keeps a live flag for each channel that says whether the clock is toggling with a period inside an allowed window.

Host software reaches the results through a byte-wide register port. A write of any value to the latch address copies the live periods of both channels into snapshot registers at the same clock edge. Software then reads each snapshot as an upper byte and a lower byte, and the snapshot does not change until the next latch write. A separate status register shows the two live toggling flags. If a clock stops, or its period is too long to count in 16 bits, the counter saturates and the period reads as all ones.

Top module: `refclk_supervisor`

## Requirements
- R1: Each channel's live period is the number of bus clock cycles between two consecutive synchronized rising edges of its input, held as a 16-bit value.
- R2: When an input stays static for 65535 bus cycles, its live period becomes 0xFFFF and its toggling flag becomes 0.
- R3: The period counter saturates at 0xFFFF. An edge that arrives after saturation gives a period of 0xFFFF, never a wrapped value.
- R4: A write of any data to address 0x67 captures both live periods in the same cycle. Channel A's snapshot reads at 0x61 (bits 15:8) and 0x60 (bits 7:0). Channel B's snapshot reads at 0x63 (bits 15:8) and 0x62 (bits 7:0).
- R5: Address 0x66 reads channel A's toggling flag in bit 0 and channel B's in bit 1. Bits 7:2 read as 0.
- R6: A snapshot keeps its value until the next write to 0x67. Writes to other addresses and changes of the input period do not alter it.
- R7: Reads of 0x67 and of any address that is not mapped return 0x00.
- R8: After reset, all four snapshot bytes read 0xFF and the status register reads 0x00.
- R9: A toggling flag is 1 only when the last complete period lies between MIN_PERIOD (default 4) and MAX_PERIOD (default 0xFFFE), inclusive. A period of 3 is still reported as 3, but its flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register address for reads and writes |
| regWr | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 8 | Write data (ignored by every register) |
| regRdData | output | 8 | Combinational read data for regAddr |
| refClkA | input | 1 | Asynchronous reference clock, channel A |
| refClkB | input | 1 | Asynchronous reference clock, channel B |

## Verification
A wrong live counter or a wrong edge detector only shows at the ports after the next latch write. It then appears as a snapshot byte that differs from the period the bench drove. A bad flag shows in the status register from the cycle after the edge that ended the period. The bench compares every register read against a behavioural model on every cycle, so a snapshot that changes without a latch write is reported in the cycle it changes. The stopped-clock and too-slow cases need more than 65535 cycles before the saturated value can appear, so the bench keeps one channel running at a 70000-cycle period while it tests the other channel.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int NUM_CH = 2;

  localparam logic [7:0] ADDR_A_LO   = 8'h60;
  localparam logic [7:0] ADDR_A_HI   = 8'h61;
  localparam logic [7:0] ADDR_B_LO   = 8'h62;
  localparam logic [7:0] ADDR_B_HI   = 8'h63;
  localparam logic [7:0] ADDR_STATUS = 8'h66;
  localparam logic [7:0] ADDR_LATCH  = 8'h67;

  typedef struct packed {
    logic              latch;
    logic              selStatus;
    logic [NUM_CH-1:0] selLo;
    logic [NUM_CH-1:0] selHi;
  } ctrlStrb_t;
endpackage

// File: rtl/refclk_period_meter.sv
module refclk_period_meter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PERIOD  = 4,
  parameter int MAX_PERIOD  = 65534
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refIn,
  output logic [CNT_W-1:0] measOut,
  output logic             togOut
);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(MIN_PERIOD);
  localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(MAX_PERIOD);

  logic [SYNC_STAGES:0] syncQ;
  logic                 rise;
  logic [CNT_W-1:0]     cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], refIn};
  end

  assign rise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= CNT_SAT;
      measOut <= CNT_SAT;
      togOut  <= 1'b0;
    end else if (rise) begin
      measOut <= cnt;
      togOut  <= (cnt >= MIN_C) && (cnt <= MAX_C);
      cnt     <= CNT_W'(1);
    end else if (cnt == CNT_SAT) begin
      measOut <= CNT_SAT;
      togOut  <= 1'b0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  AST_SAT_ALLONES: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_SAT && !rise) |=> (measOut == CNT_SAT && !togOut)); // R3
  AST_SAT_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_SAT && !rise) |=> (cnt == CNT_SAT)); // R3
  AST_TOG_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    togOut |-> (measOut >= MIN_C && measOut <= MAX_C)); // R9
  AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> (cnt == CNT_W'(1) && measOut == $past(cnt))); // R1
endmodule

// File: rtl/refclk_regctrl.sv
module refclk_regctrl
  import refclk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [7:0] regAddr,
  input  logic      regWr,
  input  logic [7:0] regWrData,
  output ctrlStrb_t strb
);
  always_comb begin
    strb           = '0;
    strb.latch     = regWr && (regAddr == ADDR_LATCH);
    strb.selStatus = (regAddr == ADDR_STATUS);
    strb.selLo[0]  = (regAddr == ADDR_A_LO);
    strb.selHi[0]  = (regAddr == ADDR_A_HI);
    strb.selLo[1]  = (regAddr == ADDR_B_LO);
    strb.selHi[1]  = (regAddr == ADDR_B_HI);
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selStatus, strb.selLo, strb.selHi})); // R7
  AST_LATCH_ANY_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_LATCH && regWrData != 8'h00) |-> strb.latch); // R4
endmodule

// File: rtl/refclk_datapath.sv
module refclk_datapath
  import refclk_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PERIOD  = 4,
  parameter int MAX_PERIOD  = 65534
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] refIn,
  input  ctrlStrb_t         strb,
  output logic [7:0]        rdData
);
  logic [NUM_CH-1:0][CNT_W-1:0] meas;
  logic [NUM_CH-1:0][CNT_W-1:0] snap;
  logic [NUM_CH-1:0]            tog;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    refclk_period_meter #(
      .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES),
      .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD)
    ) uMeter (
      .clk(clk), .rstN(rstN), .refIn(refIn[ch]),
      .measOut(meas[ch]), .togOut(tog[ch])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           snap[ch] <= '1;
      else if (strb.latch) snap[ch] <= meas[ch];
    end

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !strb.latch |=> $stable(snap[ch])); // R6
    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
      strb.latch |=> (snap[ch] == $past(meas[ch]))); // R4
  end

  always_comb begin
    logic [15:0] wide;
    rdData = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      wide = 16'(snap[ch]);
      if (strb.selLo[ch]) rdData = rdData | wide[7:0];
      if (strb.selHi[ch]) rdData = rdData | wide[15:8];
    end
    if (strb.selStatus) rdData = rdData | 8'(tog);
  end

  AST_STATUS_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    strb.selStatus |-> (rdData[7:NUM_CH] == '0)); // R5
endmodule

// File: rtl/refclk_supervisor.sv
module refclk_supervisor
  import refclk_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PERIOD  = 4,
  parameter int MAX_PERIOD  = 65534
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] regAddr,
  input  logic       regWr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       refClkA,
  input  logic       refClkB
);
  ctrlStrb_t strb;

  refclk_regctrl uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .strb(strb)
  );

  refclk_datapath #(
    .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES),
    .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD)
  ) uData (
    .clk(clk), .rstN(rstN), .refIn({refClkB, refClkA}),
    .strb(strb), .rdData(regRdData)
  );
endmodule

// File: tb/tb_refclk_supervisor.sv
module tb_refclk_supervisor;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic       regWr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       refClkA = 1'b0;
  logic       refClkB = 1'b0;

  int nVec = 0;
  int nBad = 0;

  refclk_supervisor dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData),
    .refClkA(refClkA), .refClkB(refClkB)
  );

  always #10 clk = ~clk;

  // reference clock generators, driven away from the sampling edge
  int hiLen[2] = '{0, 0};
  int loLen[2] = '{0, 0};
  int phase[2] = '{0, 0};
  logic lvl[2] = '{1'b0, 1'b0};

  always @(negedge clk) begin
    for (int ch = 0; ch < 2; ch++) begin
      if (hiLen[ch] == 0) begin
        lvl[ch] = 1'b0; phase[ch] = 0;
      end else begin
        phase[ch]++;
        if (lvl[ch] && phase[ch] >= hiLen[ch]) begin lvl[ch] = 1'b0; phase[ch] = 0; end
        else if (!lvl[ch] && phase[ch] >= loLen[ch]) begin lvl[ch] = 1'b1; phase[ch] = 0; end
      end
    end
    refClkA = lvl[0];
    refClkB = lvl[1];
  end

  // behavioural reference model
  int   mCnt[2], mMeas[2], mSnap[2];
  bit   mTog[2];
  bit   hist[2][3];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int ch = 0; ch < 2; ch++) begin
        mCnt[ch] = 65535; mMeas[ch] = 65535; mSnap[ch] = 65535; mTog[ch] = 0;
        for (int j = 0; j < 3; j++) hist[ch][j] = 0;
      end
    end else begin
      if (regWr && regAddr == 8'h67)
        for (int ch = 0; ch < 2; ch++) mSnap[ch] = mMeas[ch];
      for (int ch = 0; ch < 2; ch++) begin
        if (hist[ch][1] && !hist[ch][2]) begin
          mMeas[ch] = mCnt[ch];
          mTog[ch]  = (mCnt[ch] >= 4) && (mCnt[ch] <= 65534);
          mCnt[ch]  = 1;
        end else if (mCnt[ch] >= 65535) begin
          mMeas[ch] = 65535; mTog[ch] = 0;
        end else begin
          mCnt[ch]++;
        end
        hist[ch][2] = hist[ch][1];
        hist[ch][1] = hist[ch][0];
        hist[ch][0] = (ch == 0) ? refClkA : refClkB;
      end
    end
  end

  function automatic logic [7:0] modelRead(logic [7:0] a);
    case (a)
      8'h60: return 8'(mSnap[0]);
      8'h61: return 8'(mSnap[0] >> 8);
      8'h62: return 8'(mSnap[1]);
      8'h63: return 8'(mSnap[1] >> 8);
      8'h66: return {6'b0, mTog[1], mTog[0]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string reqOf(logic [7:0] a);
    if (a == 8'h66) return "R5";
    if (a >= 8'h60 && a <= 8'h63) return "R4";
    return "R7";
  endfunction

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (rstN) begin
      nVec++;
      if (regRdData !== modelRead(regAddr)) begin
        nBad++;
        $display("FAIL %s model addr=%02h got=%02h exp=%02h", reqOf(regAddr),
                 regAddr, regRdData, modelRead(regAddr));
      end
    end
  end

  task automatic readChk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #2;
    nVec++;
    if (regRdData !== exp) begin
      nBad++;
      $display("FAIL %s addr=%02h got=%02h exp=%02h", tag, a, regRdData, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic setPer(input int ch, input int hi, input int lo);
    hiLen[ch] = hi; loLen[ch] = lo;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    #(200000 * 20);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    // R8: reset values
    readChk(8'h60, 8'hFF, "R8");
    readChk(8'h61, 8'hFF, "R8");
    readChk(8'h62, 8'hFF, "R8");
    readChk(8'h63, 8'hFF, "R8");
    readChk(8'h66, 8'h00, "R8");

    // channel B: over-long period for the saturation case
    setPer(1, 35000, 35000);
    // R1: channel A period 10
    setPer(0, 5, 5);
    waitCyc(60);
    regWrite(8'h67, 8'hA5);
    readChk(8'h60, 8'h0A, "R1");
    readChk(8'h61, 8'h00, "R4");
    readChk(8'h62, 8'hFF, "R2");
    readChk(8'h66, 8'h01, "R5");

    // R6: period change and a foreign write leave the snapshot alone
    setPer(0, 10, 10);
    waitCyc(100);
    regWrite(8'h60, 8'h00);
    readChk(8'h60, 8'h0A, "R6");
    regWrite(8'h67, 8'h00);
    readChk(8'h60, 8'h14, "R4");

    // R9: period 3 below window
    setPer(0, 2, 1);
    waitCyc(40);
    regWrite(8'h67, 8'h3C);
    readChk(8'h60, 8'h03, "R9");
    readChk(8'h66, 8'h00, "R9");

    // asymmetric duty cycle, period 12
    setPer(0, 9, 3);
    waitCyc(60);
    regWrite(8'h67, 8'hFF);
    readChk(8'h60, 8'h0C, "R1");
    readChk(8'h66, 8'h01, "R9");

    // R2: channel A stopped; R3: channel B edges 70000 apart
    setPer(0, 0, 0);
    waitCyc(110000);
    regWrite(8'h67, 8'h11);
    readChk(8'h60, 8'hFF, "R2");
    readChk(8'h61, 8'hFF, "R2");
    readChk(8'h62, 8'hFF, "R3");
    readChk(8'h63, 8'hFF, "R3");
    readChk(8'h66, 8'h00, "R2");

    // both channels running again
    setPer(0, 5, 5);
    setPer(1, 150, 150);
    waitCyc(1000);
    regWrite(8'h67, 8'h00);
    readChk(8'h60, 8'h0A, "R4");
    readChk(8'h62, 8'h2C, "R4");
    readChk(8'h63, 8'h01, "R4");
    readChk(8'h66, 8'h03, "R5");

    // R7: latch address and unmapped addresses read zero
    readChk(8'h67, 8'h00, "R7");
    readChk(8'h64, 8'h00, "R7");
    readChk(8'h70, 8'h00, "R7");

    waitCyc(5);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule